// File: doc/BRIEF.md
# Triggered Latency Buffer with Serial Readout

The block takes a 128-bit word of channel hits on every clock and writes it into a circular history memory. When a level-1 trigger arrives, it does not keep the word present at that moment. It keeps the word that was sampled a programmed number of clocks earlier. That word is the one in time with the physics crossing the trigger refers to.

The selected word is stored in an event queue with two tags: a wrapping 12-bit crossing counter and an 8-bit count of accepted triggers, both taken at the trigger edge. Whenever the queue holds an event, a serializer sends it out on one data line, header first and then the channel bits, while a data-valid strobe is high. A synchronous count-reset input restarts both counters and empties the queue. A trigger that finds the queue full is dropped and raises a sticky overflow flag.

Top module: `trig_latbuf`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `sdv_o`, `sdata_o` and `ovf_o` are all low.
- R2: For a trigger sampled at clock edge k with `latency_i` = L (0 to 255), the stored channel word is the `hit_i` value sampled at edge k−L. L = 0 selects the word present at the trigger edge itself.
- R3: The crossing counter is 12 bits wide. It reads 0 at the first edge after reset or count reset, increments on every clock and wraps from 4095 to 0. A frame carries the value the counter held at its trigger edge.
- R4: The event count in a frame equals the number of triggers accepted since reset or count reset before this one, so the first frame carries 0.
- R5: The queue holds 128 events. A trigger that finds the queue full produces no frame and leaves the event count unchanged. It also sets `ovf_o`, which stays high until `rst`.
- R6: `cnt_rst_i` clears the crossing counter and the event counter and discards queued events that have not started. A frame already on the line finishes normally.
- R7: A frame is 148 bits, one per clock, each field sent MSB first. The order is crossing count [11:0], then event count [7:0], then channel 127 down to channel 0. `sdv_o` is high for exactly those 148 clocks.
- R8: When the queue is empty and the line is idle, a trigger at edge k makes the first frame bit valid after edge k+1.
- R9: Frames leave in trigger order. There is at least one clock with `sdv_o` low between consecutive frames.
- R10: A trigger on the same edge as `cnt_rst_i` is ignored: it makes no frame and does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 128 | Channel hit word sampled every clock |
| trig_i | input | 1 | Level-1 trigger, one event per high cycle |
| latency_i | input | 8 | Trigger latency in clocks |
| cnt_rst_i | input | 1 | Synchronous reset of counters and queue |
| sdata_o | output | 1 | Serial frame data |
| sdv_o | output | 1 | High while frame bits are on `sdata_o` |
| ovf_o | output | 1 | Sticky flag: a trigger was dropped on a full queue |

## Verification
The assertions check the invariants that hold on every cycle. These are the step and wrap of the crossing counter, an event count that moves only on accepted triggers, a dropped trigger setting the sticky overflow flag, a frame that opens at full length and ends with an idle clock, and the serializer taking from the queue only when it is idle. Other behaviour depends on the end-to-end data path, and only the bench scenarios show it. This covers the word selected at each latency across the whole range, the exact header and channel bits of every frame, the cycle at which a frame starts, the 129 frames delivered out of a 140-trigger burst, and the events discarded by a count reset.

// File: rtl/trig_lb_pkg.sv
package trig_lb_pkg;

    localparam int CHANS   = 128;
    localparam int LAT_W   = 8;
    localparam int BX_W    = 12;
    localparam int EV_W    = 8;
    localparam int QDEPTH  = 128;
    localparam int FRAME_W = BX_W + EV_W + CHANS;

    // Packed so that the flattened vector is the on-wire order, MSB first.
    typedef struct packed {
        logic [BX_W-1:0]  bx;
        logic [EV_W-1:0]  evn;
        logic [CHANS-1:0] hits;
    } event_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_SEND = 2'd1,
        SER_GAP  = 2'd2
    } ser_state_e;

    function automatic event_t make_event(input logic [BX_W-1:0] bx,
                                          input logic [EV_W-1:0] evn,
                                          input logic [CHANS-1:0] hits);
        event_t e;
        e.bx   = bx;
        e.evn  = evn;
        e.hits = hits;
        return e;
    endfunction

endpackage

// File: rtl/trig_lb_ring.sv
module trig_lb_ring #(
    parameter int W  = 128,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  hit_i,
    input  logic [AW-1:0] dly_i,
    output logic [W-1:0]  word_o
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rd_addr;

    always_ff @(posedge clk) begin
        if (rst) wp <= '0;
        else     wp <= wp + AW'(1);
    end

    always_ff @(posedge clk) begin
        mem[wp] <= hit_i;
    end

    // wp-1 holds the previous edge's sample; modulo arithmetic wraps the ring.
    assign rd_addr = wp - dly_i;
    assign word_o  = (dly_i == '0) ? hit_i : mem[rd_addr];

endmodule

// File: rtl/trig_lb_evq.sv
module trig_lb_evq
    import trig_lb_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_i,
    input  logic   push_i,
    input  event_t push_data_i,
    input  logic   pop_i,
    output event_t head_o,
    output logic   nonempty_o,
    output logic   accept_o,
    output logic   ovf_o
);
    localparam int AW = $clog2(DEPTH);

    event_t        store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          full, do_pop, drop;

    assign full       = (count == (AW+1)'(DEPTH));
    assign nonempty_o = (count != '0);
    assign accept_o   = push_i && !full;
    assign drop       = push_i && full;
    assign do_pop     = pop_i && nonempty_o;
    assign head_o     = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept_o) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)   rd_ptr <= rd_ptr + AW'(1);
            count <= count + (AW+1)'(accept_o) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (accept_o) store[wr_ptr] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst)       ovf_o <= 1'b0;
        else if (drop) ovf_o <= 1'b1;
    end

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf_o); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R5
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (drop && !do_pop && !clr_i) |=> $stable(count)); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !nonempty_o); // R6

endmodule

// File: rtl/trig_lb_ser.sv
module trig_lb_ser
    import trig_lb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   avail_i,
    input  event_t head_i,
    output logic   pop_o,
    output logic   sdata_o,
    output logic   sdv_o
);
    localparam int CW = $clog2(FRAME_W);

    ser_state_e           state;
    logic [CW-1:0]        cnt;
    logic [FRAME_W-1:0]   sr;

    assign pop_o   = (state == SER_IDLE) && avail_i;
    assign sdv_o   = (state == SER_SEND);
    assign sdata_o = sr[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            cnt   <= '0;
            sr    <= '0;
        end else begin
            unique case (state)
                SER_IDLE: if (avail_i) begin
                    sr    <= head_i;
                    cnt   <= CW'(FRAME_W - 1);
                    state <= SER_SEND;
                end
                SER_SEND: begin
                    sr <= {sr[FRAME_W-2:0], 1'b0};
                    if (cnt == '0) state <= SER_GAP;
                    else           cnt   <= cnt - CW'(1);
                end
                SER_GAP:  state <= SER_IDLE;
                default:  state <= SER_IDLE;
            endcase
        end
    end

    AST_FRAME_OPENS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(sdv_o) |-> (cnt == CW'(FRAME_W - 1))); // R7
    AST_GAP_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        (sdv_o && cnt == '0) |=> !sdv_o); // R9
    AST_POP_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        pop_o |=> sdv_o); // R8

endmodule

// File: rtl/trig_latbuf.sv
module trig_latbuf
    import trig_lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CHANS-1:0] hit_i,
    input  logic             trig_i,
    input  logic [LAT_W-1:0] latency_i,
    input  logic             cnt_rst_i,
    output logic             sdata_o,
    output logic             sdv_o,
    output logic             ovf_o
);
    logic [BX_W-1:0]  bx_cnt;
    logic [EV_W-1:0]  ev_cnt;
    logic [CHANS-1:0] delayed_word;
    logic             push, accept, avail, pop;
    event_t           head;

    trig_lb_ring #(.W(CHANS), .AW(LAT_W)) i_ring (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit_i),
        .dly_i  (latency_i),
        .word_o (delayed_word)
    );

    assign push = trig_i && !cnt_rst_i;

    trig_lb_evq #(.DEPTH(QDEPTH)) i_evq (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (cnt_rst_i),
        .push_i      (push),
        .push_data_i (make_event(bx_cnt, ev_cnt, delayed_word)),
        .pop_i       (pop),
        .head_o      (head),
        .nonempty_o  (avail),
        .accept_o    (accept),
        .ovf_o       (ovf_o)
    );

    trig_lb_ser i_ser (
        .clk     (clk),
        .rst     (rst),
        .avail_i (avail),
        .head_i  (head),
        .pop_o   (pop),
        .sdata_o (sdata_o),
        .sdv_o   (sdv_o)
    );

    always_ff @(posedge clk) begin
        if (rst || cnt_rst_i) bx_cnt <= '0;
        else                  bx_cnt <= bx_cnt + BX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_rst_i) ev_cnt <= '0;
        else if (accept)      ev_cnt <= ev_cnt + EV_W'(1);
    end

    AST_BX_STEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_rst_i |=> (bx_cnt == $past(bx_cnt) + BX_W'(1))); // R3
    AST_BX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!cnt_rst_i && bx_cnt == '1) |=> (bx_cnt == '0)); // R3
    AST_EVN_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (accept && !cnt_rst_i) |=> (ev_cnt == $past(ev_cnt) + EV_W'(1))); // R4
    AST_EVN_HOLD_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (!accept && !cnt_rst_i) |=> $stable(ev_cnt)); // R5
    AST_CNT_RST_IGNORES_TRIG: assert property (@(posedge clk) disable iff (rst)
        cnt_rst_i |=> (ev_cnt == '0 && bx_cnt == '0)); // R10

endmodule

// File: tb/test_trig_latbuf.sv
`timescale 1ns/1ps
module test_trig_latbuf;
    import trig_lb_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CHANS-1:0] hit_i = '0;
    logic             trig_i = 1'b0;
    logic [LAT_W-1:0] latency_i = '0;
    logic             cnt_rst_i = 1'b0;
    logic             sdata_o, sdv_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    int bx_base = 0;
    int ev_model = 0;
    logic [FRAME_W-1:0] expq [$];

    always #4 clk = ~clk;

    trig_latbuf i_trig_latbuf (
        .clk       (clk),
        .rst       (rst),
        .hit_i     (hit_i),
        .trig_i    (trig_i),
        .latency_i (latency_i),
        .cnt_rst_i (cnt_rst_i),
        .sdata_o   (sdata_o),
        .sdv_o     (sdv_o),
        .ovf_o     (ovf_o)
    );

    function automatic logic [CHANS-1:0] hitpat(input int n);
        logic [31:0] u;
        u = n;
        return {u * 32'h9E3779B1, ~u, u ^ 32'h5A5A5A5A, {u[15:0], u[31:16]}};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Edge index of the next rising edge, counted from the first edge out of reset.
    always @(posedge clk) if (!rst) edge_n++;
    always @(negedge clk) hit_i <= hitpat(edge_n);

    // Frame monitor
    bit                 in_frame = 0;
    bit                 seen_frame = 0;
    int                 nbits = 0;
    int                 idle_cnt = 0;
    logic [FRAME_W-1:0] fbuf = '0;
    logic [FRAME_W-1:0] ef;

    always @(negedge clk) if (!rst) begin
        if (sdv_o) begin
            if (!in_frame) begin
                in_frame = 1;
                nbits = 0;
                if (seen_frame) chk(idle_cnt >= 1, "R9 idle gap between frames", idle_cnt, 1);
            end
            fbuf = {fbuf[FRAME_W-2:0], sdata_o};
            nbits++;
        end else begin
            if (in_frame) begin
                in_frame = 0;
                seen_frame = 1;
                idle_cnt = 0;
                chk(nbits == FRAME_W, "R7 frame length", nbits, FRAME_W);
                if (expq.size() == 0) begin
                    chk(0, "R9 unexpected frame", fbuf, '0);
                end else begin
                    ef = expq.pop_front();
                    chk(fbuf[FRAME_W-1 -: BX_W] == ef[FRAME_W-1 -: BX_W], "R3 crossing count", fbuf[FRAME_W-1 -: BX_W], ef[FRAME_W-1 -: BX_W]);
                    chk(fbuf[CHANS +: EV_W] == ef[CHANS +: EV_W], "R4 event count", fbuf[CHANS +: EV_W], ef[CHANS +: EV_W]);
                    chk(fbuf[CHANS-1:0] == ef[CHANS-1:0], "R2 delayed channel word", fbuf[CHANS-1:0], ef[CHANS-1:0]);
                end
            end
            idle_cnt++;
        end
    end

    // Called and returns at a falling edge; trigger covers exactly one rising edge.
    task automatic fire(input bit counts, input bit framed);
        int n;
        logic [BX_W-1:0] bxe;
        trig_i = 1'b1;
        n = edge_n;
        bxe = BX_W'((n - bx_base) % 4096);
        if (framed) expq.push_back({bxe, EV_W'(ev_model), hitpat(n - int'(latency_i))});
        if (counts) ev_model++;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic do_cnt_rst(input bit with_trig);
        cnt_rst_i = 1'b1;
        trig_i = with_trig;
        bx_base = edge_n + 1;
        ev_model = 0;
        @(negedge clk);
        cnt_rst_i = 1'b0;
        trig_i = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic drain;
        int t;
        t = 0;
        while ((expq.size() != 0 || sdv_o) && t < 30000) begin
            @(negedge clk);
            t++;
        end
        idle(3);
        chk(expq.size() == 0, "R9 all expected frames delivered in order", expq.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int lats[8] = '{0, 1, 2, 3, 7, 64, 200, 255};
        repeat (5) @(negedge clk);
        chk(sdv_o == 1'b0 && sdata_o == 1'b0 && ovf_o == 1'b0, "R1 outputs during reset", {sdv_o, sdata_o, ovf_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sdv_o == 1'b0 && ovf_o == 1'b0, "R1 outputs after reset", {sdv_o, ovf_o}, 0);
        idle(300);

        // Latency sweep with start-latency check
        for (int i = 0; i < 8; i++) begin
            latency_i = LAT_W'(lats[i]);
            idle(2);
            fire(1, 1);
            chk(sdv_o == 1'b0, "R8 no data on trigger edge", sdv_o, 0);
            idle(1);
            chk(sdv_o == 1'b1, "R8 first bit after next edge", sdv_o, 1);
            drain();
        end

        // Back-to-back triggers
        latency_i = 8'd10;
        for (int i = 0; i < 4; i++) fire(1, 1);
        drain();

        // Crossing-count wrap
        latency_i = 8'd5;
        while (((edge_n - bx_base) % 4096) != 4094) @(negedge clk);
        for (int i = 0; i < 3; i++) fire(1, 1);
        drain();

        // Overflow: 140 consecutive triggers, 129 fit (one slot freed by the first pop)
        chk(ovf_o == 1'b0, "R5 no overflow before burst", ovf_o, 0);
        latency_i = 8'd33;
        for (int i = 0; i < 140; i++) fire(i < 129, i < 129);
        chk(ovf_o == 1'b1, "R5 overflow flag set", ovf_o, 1);
        drain();
        chk(ovf_o == 1'b1, "R5 overflow flag sticky", ovf_o, 1);
        fire(1, 1);
        drain();

        // Count reset discards queued events; frame in progress completes
        latency_i = 8'd17;
        fire(1, 1);
        fire(1, 0);
        fire(1, 0);
        idle(2);
        do_cnt_rst(0);
        idle(20);
        fire(1, 1);
        drain();
        chk(ovf_o == 1'b1, "R6 count reset leaves overflow flag", ovf_o, 1);

        // Trigger coinciding with count reset is ignored
        idle(4);
        do_cnt_rst(1);
        idle(3);
        chk(sdv_o == 1'b0, "R10 no frame from trigger during count reset", sdv_o, 0);
        fire(1, 1);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule